// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status and Mask Unit

This block collects interrupt events for a two-channel IDE host adapter and presents them on a small byte-wide I/O register bus. Each channel has two sticky status flags. One records an interrupt raised by the attached drive. The other records completion of a bus-master transfer. A per-channel mask gates the flags onto one interrupt line per channel, and each line has its own output polarity.

Two bus offsets carry all of the state. Offset 2 is shared: a write loads a chip mode register with a legacy-compatible flag and a test flag, and a read returns the channel-0 status flags. Offset 3 holds the two mask bits. A read of offset 3 also returns the channel-1 status flags and the level of a strap pin that reports whether a legacy header is fitted.

Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the address. The drives, the DMA engine and the host bus interface sit outside the block.

Top module: `ide_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all status flags, both mask bits, `legacy_mode` and `test_mode` become 0. With `irq_pol_low` at 0, both interrupt lines are then low.
- R2: A drive-status flag becomes 1 at the first clock edge at which its `drv_evt` input is sampled high after having been sampled low. It stays 1 while the input stays high.
- R3: A drive-status flag clears at the first clock edge at which its `drv_evt` input is sampled low after having been sampled high.
- R4: A bus-master flag becomes 1 on a sampled rise of `bm_evt`. It clears on a sampled fall of `bm_evt`, or at an edge where `bm_ack` is high. When a rise and `bm_ack` occur at the same edge, the rise wins and the flag is set.
- R5: A read at offset 2 returns channel-0 bus-master status in bit 1 and channel-0 drive status in bit 0. Bits 7 to 2 read as 0.
- R6: A read at offset 3 returns the following: `legacy_hdr_strap` in bit 4, channel-1 bus-master status in bit 3, channel-1 drive status in bit 2, and the channel-1 and channel-0 mask bits in bits 1 and 0. Bits 7 to 5 read as 0.
- R7: A strobed write at offset 3 loads the mask bits from data bits 1:0 (1 = masked). Data bits 7 to 2 have no effect, so the status flags cannot be written.
- R8: A strobed write at offset 2 with data bit 7 set loads `legacy_mode` from bit 1 and `test_mode` from bit 0. With data bit 7 clear, the write is discarded. Neither kind of write alters the channel-0 status flags.
- R9: A channel is active when either of its status flags is 1 and its mask bit is 0. Its `irq_line` equals the active value XOR its `irq_pol_low` bit, so 1 selects active-low and 0 selects active-high. The line follows `irq_pol_low` in the same cycle.
- R10: A read at any offset other than 2 or 3 returns 0. With `bus_wr` low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| drv_evt | input | 2 | Drive interrupt event, one bit per channel |
| bm_evt | input | 2 | Bus-master completion event, one bit per channel |
| bm_ack | input | 2 | Bus-master completion acknowledge, one bit per channel |
| irq_pol_low | input | 2 | Per-channel output polarity, 1 = active low |
| legacy_hdr_strap | input | 1 | Strap level: legacy header present |
| irq_line | output | 2 | Per-channel interrupt lines |
| legacy_mode | output | 1 | Mode register: legacy-compatible (1) or native (0) |
| test_mode | output | 1 | Mode register: test mode |

## Verification
The bench covers three collisions on the bus-master flag: an acknowledge arriving in the same cycle as a fresh rise, an acknowledge while the event stays high, and an event that falls without an acknowledge. A design that let the acknowledge win would lose a completion. A design that ignored the fall would leave a stale interrupt asserted.

It also writes all ones to the mask offset and checks that the channel-1 status and the strap bit do not change. A design that stored those bits would report fake status.

It writes the mode offset with bit 7 clear and checks that the mode is unchanged and the channel-0 status survives. A design missing the key check would switch modes by accident.

Finally, it flips the polarity pins while a channel is active and while it is masked. This catches an output stage that inverts in the wrong place, or one that registers the polarity.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

    localparam int NUM_CH     = 2;
    localparam int DATA_W     = 8;
    localparam int OFS_STAT0  = 2;
    localparam int OFS_MASK   = 3;
    localparam int MODE_KEY   = 7;
    localparam int STRAP_BIT  = 4;

    typedef struct packed {
        logic bm;
        logic drv;
    } chan_stat_t;

    typedef struct packed {
        logic legacy;
        logic test;
    } mode_t;

    function automatic logic chan_active(chan_stat_t s, logic masked);
        return (s.bm | s.drv) & ~masked;
    endfunction

endpackage

// File: rtl/ide_irq_chan.sv
module ide_irq_chan
    import ide_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       drv_evt,
    input  logic       bm_evt,
    input  logic       bm_ack,
    output chan_stat_t stat
);

    logic       drv_q;
    logic       bm_q;
    chan_stat_t stat_q;
    logic       drv_rise, drv_fall, bm_rise, bm_fall;

    always_comb begin
        drv_rise = drv_evt & ~drv_q;
        drv_fall = ~drv_evt & drv_q;
        bm_rise  = bm_evt & ~bm_q;
        bm_fall  = ~bm_evt & bm_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q  <= 1'b0;
            bm_q   <= 1'b0;
            stat_q <= '0;
        end else begin
            drv_q <= drv_evt;
            bm_q  <= bm_evt;
            if (drv_rise)
                stat_q.drv <= 1'b1;
            else if (drv_fall)
                stat_q.drv <= 1'b0;
            if (bm_rise)
                stat_q.bm <= 1'b1;
            else if (bm_fall || bm_ack)
                stat_q.bm <= 1'b0;
        end
    end

    assign stat = stat_q;

endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
    import ide_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  chan_stat_t [NUM_CH-1:0]  stat,
    input  logic                     strap,
    output logic [NUM_CH-1:0]        mask,
    output mode_t                    mode,
    output logic [DATA_W-1:0]        bus_rdata
);

    localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(OFS_STAT0);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

    logic [NUM_CH-1:0] mask_q;
    mode_t             mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            mode_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MASK)
                mask_q <= bus_wdata[NUM_CH-1:0];
            else if (bus_addr == A_STAT0 && bus_wdata[MODE_KEY])
                mode_q <= mode_t'(bus_wdata[1:0]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAT0) begin
            bus_rdata[1:0] = stat[0];
        end else if (bus_addr == A_MASK) begin
            bus_rdata[NUM_CH-1:0] = mask_q;
            bus_rdata[3:2]        = stat[1];
            bus_rdata[STRAP_BIT]  = strap;
        end
    end

    assign mask = mask_q;
    assign mode = mode_q;

endmodule

// File: rtl/ide_irq_out.sv
module ide_irq_out
    import ide_irq_pkg::*;
(
    input  chan_stat_t [NUM_CH-1:0] stat,
    input  logic [NUM_CH-1:0]       mask,
    input  logic [NUM_CH-1:0]       pol_low,
    output logic [NUM_CH-1:0]       irq_line
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_line
        assign irq_line[g] = chan_active(stat[g], mask[g]) ^ pol_low[g];
    end

endmodule

// File: rtl/ide_irq_ctrl.sv
module ide_irq_ctrl
    import ide_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        drv_evt,
    input  logic [1:0]        bm_evt,
    input  logic [1:0]        bm_ack,
    input  logic [1:0]        irq_pol_low,
    input  logic              legacy_hdr_strap,
    output logic [1:0]        irq_line,
    output logic              legacy_mode,
    output logic              test_mode
);

    chan_stat_t [NUM_CH-1:0] stat_w;
    logic [NUM_CH-1:0]       mask_w;
    mode_t                   mode_w;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ide_irq_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .drv_evt (drv_evt[c]),
            .bm_evt  (bm_evt[c]),
            .bm_ack  (bm_ack[c]),
            .stat    (stat_w[c])
        );
    end

    ide_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat      (stat_w),
        .strap     (legacy_hdr_strap),
        .mask      (mask_w),
        .mode      (mode_w),
        .bus_rdata (bus_rdata)
    );

    ide_irq_out u_out (
        .stat     (stat_w),
        .mask     (mask_w),
        .pol_low  (irq_pol_low),
        .irq_line (irq_line)
    );

    assign legacy_mode = mode_w.legacy;
    assign test_mode   = mode_w.test;

endmodule

// File: rtl/ide_irq_ctrl_chk.sv
module ide_irq_ctrl_chk
    import ide_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_wr,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [7:0]              bus_wdata,
    input logic [7:0]              bus_rdata,
    input logic [1:0]              drv_evt,
    input logic [1:0]              bm_evt,
    input logic [1:0]              bm_ack,
    input logic [1:0]              irq_pol_low,
    input logic [1:0]              irq_line,
    input logic                    legacy_mode,
    input logic                    test_mode,
    input chan_stat_t [NUM_CH-1:0] stat,
    input logic [NUM_CH-1:0]       mask
);

    localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(OFS_STAT0);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (mask == '0) && !legacy_mode && !test_mode && (stat == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // R2
        drv_set_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && drv_evt[g] && !$past(drv_evt[g])) |=> stat[g].drv);

        // R3
        drv_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !drv_evt[g] && $past(drv_evt[g])) |=> !stat[g].drv);

        // R4
        bm_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && bm_ack[g] && !(bm_evt[g] && !$past(bm_evt[g])))
            |=> !stat[g].bm);

        // R9
        line_active_chk: assert property (@(posedge clk) disable iff (rst)
            ((stat[g].bm || stat[g].drv) && !mask[g]) |-> (irq_line[g] != irq_pol_low[g]));

        // R9
        line_idle_chk: assert property (@(posedge clk) disable iff (rst)
            mask[g] |-> (irq_line[g] == irq_pol_low[g]));
    end

    // R5
    stat0_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_STAT0) |-> (bus_rdata[7:2] == 6'd0));

    // R6
    mask_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_MASK) |-> (bus_rdata[1:0] == mask));

    // R7
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_MASK) |=> (mask == $past(bus_wdata[1:0])));

    // R8
    mode_key_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_STAT0 && !bus_wdata[MODE_KEY])
        |=> ($stable(legacy_mode) && $stable(test_mode)));

    // R10
    no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(mask) && $stable(legacy_mode) && $stable(test_mode)));

endmodule

bind ide_irq_ctrl ide_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .drv_evt     (drv_evt),
    .bm_evt      (bm_evt),
    .bm_ack      (bm_ack),
    .irq_pol_low (irq_pol_low),
    .irq_line    (irq_line),
    .legacy_mode (legacy_mode),
    .test_mode   (test_mode),
    .stat        (stat_w),
    .mask        (mask_w)
);

// File: tb/ide_irq_ctrl_test.sv
`timescale 1ns/1ps
module ide_irq_ctrl_test;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [1:0]    drv_evt = '0;
    logic [1:0]    bm_evt = '0;
    logic [1:0]    bm_ack = '0;
    logic [1:0]    irq_pol_low = '0;
    logic          legacy_hdr_strap = 1'b0;
    logic [1:0]    irq_line;
    logic          legacy_mode;
    logic          test_mode;

    always #2 clk = ~clk;

    ide_irq_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_evt(drv_evt),
        .bm_evt(bm_evt), .bm_ack(bm_ack), .irq_pol_low(irq_pol_low),
        .legacy_hdr_strap(legacy_hdr_strap), .irq_line(irq_line),
        .legacy_mode(legacy_mode), .test_mode(test_mode)
    );

    // behavioural reference state
    int m_drv[2], m_bm[2], m_pd[2], m_pb[2], m_mask[2];
    int m_leg, m_tst;
    int total = 0, fails = 0;
    bit done = 0;
    string cur_req = "R1";

    task automatic check(int act, int exp, string tag, string what);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_drv[c] = 0; m_bm[c] = 0; m_pd[c] = 0; m_pb[c] = 0; m_mask[c] = 0;
            end
            m_leg = 0; m_tst = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (drv_evt[c] && m_pd[c] == 0) m_drv[c] = 1;
                else if (!drv_evt[c] && m_pd[c] == 1) m_drv[c] = 0;
                if (bm_evt[c] && m_pb[c] == 0) m_bm[c] = 1;
                else if ((!bm_evt[c] && m_pb[c] == 1) || bm_ack[c]) m_bm[c] = 0;
                m_pd[c] = drv_evt[c];
                m_pb[c] = bm_evt[c];
            end
            if (bus_wr) begin
                if (bus_addr == 3) begin
                    m_mask[0] = bus_wdata[0];
                    m_mask[1] = bus_wdata[1];
                end else if (bus_addr == 2 && bus_wdata[7]) begin
                    m_leg = bus_wdata[1];
                    m_tst = bus_wdata[0];
                end
            end
        end
    endtask

    function automatic int exp_rd();
        if (bus_addr == 2) return m_bm[0] * 2 + m_drv[0];
        if (bus_addr == 3) return legacy_hdr_strap * 16 + m_bm[1] * 8 + m_drv[1] * 4
                                  + m_mask[1] * 2 + m_mask[0];
        return 0;
    endfunction

    function automatic int exp_irq();
        int r = 0;
        for (int c = 0; c < 2; c++) begin
            int act = ((m_drv[c] | m_bm[c]) & ~m_mask[c]) & 1;
            r += ((act ^ irq_pol_low[c]) & 1) << c;
        end
        return r;
    endfunction

    task automatic compare();
        check(bus_rdata, exp_rd(), cur_req, "rdata");
        check(irq_line, exp_irq(), cur_req, "irq_line");
        check({legacy_mode, test_mode}, m_leg * 2 + m_tst, cur_req, "mode");
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            bus_addr = 2; cyc();
            bus_addr = 3; cyc();
        end
    endtask

    task automatic wr(int a, int d);
        bus_wr = 1; bus_addr = AW'(a); bus_wdata = 8'(d);
        cyc();
        bus_wr = 0; bus_wdata = 0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        rst = 1; drv_evt = 2'b11;
        repeat (3) cyc();
        drv_evt = 0;
        idle(1);
        rst = 0;
        idle(2);

        // R2 / R3: drive status, channel 0 then 1
        cur_req = "R2";
        drv_evt[0] = 1; idle(3);
        cur_req = "R3";
        drv_evt[0] = 0; idle(2);
        cur_req = "R2";
        drv_evt[1] = 1; idle(2);
        cur_req = "R3";
        drv_evt[1] = 0; idle(1);

        // R4: bus-master flag
        cur_req = "R4";
        bm_evt[0] = 1; idle(2);
        bm_ack[0] = 1; bus_addr = 2; cyc(); bm_ack[0] = 0; idle(1);
        bm_evt[0] = 0; idle(1);
        bm_evt[0] = 1; bm_ack[0] = 1; bus_addr = 2; cyc();
        bm_ack[0] = 0; idle(1);
        bm_evt[0] = 0; idle(1);
        bm_evt[1] = 1; idle(1);
        bm_evt[1] = 0; idle(1);
        bm_evt[1] = 1; idle(1);
        bm_ack[1] = 1; bus_addr = 3; cyc(); bm_ack[1] = 0;
        bm_evt[1] = 0; idle(1);

        // R5 / R6: read layout with strap and status set
        cur_req = "R6";
        legacy_hdr_strap = 1;
        drv_evt = 2'b11; bm_evt = 2'b11;
        idle(2);
        cur_req = "R5";
        idle(1);

        // R7: mask writes; upper bits ignored
        cur_req = "R7";
        wr(3, 8'hFC); idle(1);
        wr(3, 8'hFD); idle(1);
        wr(3, 8'hFF); idle(1);
        wr(3, 8'h02); idle(1);

        // R9: polarity, active and masked
        cur_req = "R9";
        irq_pol_low = 2'b01; bus_addr = 2; cyc();
        irq_pol_low = 2'b11; bus_addr = 3; cyc();
        wr(3, 8'h00);
        irq_pol_low = 2'b10; idle(1);
        drv_evt = 0; bm_evt = 0; idle(1);
        irq_pol_low = 2'b11; idle(1);
        irq_pol_low = 2'b00; idle(1);

        // R8: mode register key bit
        cur_req = "R8";
        drv_evt[0] = 1; idle(1);
        wr(2, 8'h83); idle(1);
        wr(2, 8'h01); idle(1);
        wr(2, 8'h7E); idle(1);
        wr(2, 8'h82); idle(1);
        drv_evt[0] = 0; idle(1);

        // R10: other offsets read 0, no strobe no change
        cur_req = "R10";
        bus_addr = 0; cyc();
        bus_addr = 1; cyc();
        bus_addr = 4'hF; cyc();
        bus_wr = 0; bus_addr = 3; bus_wdata = 8'hFF; cyc();
        bus_addr = 2; bus_wdata = 8'h83; cyc();
        bus_wdata = 0; idle(2);

        // R1: reset again from a dirty state
        cur_req = "R1";
        wr(3, 8'h03); drv_evt = 2'b10; idle(1);
        rst = 1; drv_evt = 0; cyc(); cyc();
        rst = 0; idle(1);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule